// File: doc/BRIEF.md
# Transaction-Layer Packet Header Decoder (non-flit)

This block takes the header of one transaction-layer packet in the non-flit format, one 32-bit doubleword per beat. A valid strobe qualifies each beat and a start marker flags the first one. The most significant byte of each doubleword is byte 0 of the header, held in bits 31:24. The first doubleword alone decides the header length (one, three or four doublewords) and whether data follows. It also decides which kind of request or completion the packet is, or that it is a malformed packet.

When the last header doubleword has arrived, the block reports the packet kind and its posted or non-posted class. It also reports the payload size in doublewords and the fields that belong to that kind. Memory-style requests yield requester ID, tag, byte enables and address. Configuration requests yield bus, device, function and register. Completions yield completer ID, status, byte count, requester ID, tag and lower address. All results are presented together with a one-cycle done pulse and stay held until the next one. A consumer such as a receive queue or an ordering unit samples the results on the done pulse.

Top module: `tlp_hdr_decoder`

## Requirements
- R1: While reset is low and after it, before any packet completes, out_done is 0, out_err is 0, out_kind is 0 and every decoded field output is 0.
- R2: Format bits 31:29 of the first doubleword set the header size and data presence: 000 gives 3 DW with no data, 001 gives 4 DW with no data, 010 gives 3 DW with data, 011 gives 4 DW with data, and 100 gives a 1 DW prefix with no data. out_hdr_dw reports 1, 3 or 4.
- R3: Format values 101, 110 and 111 give out_err=1 with out_done one cycle after the first doubleword. On any error, out_kind, out_hdr_dw, out_has_data, out_non_posted and all field outputs are 0.
- R4: Type bits 28:24 select the kind. 00000 with data is memory write (out_kind=2), 00000 without data is memory read (1). 00100 is configuration type 0 write (4) or read (3). 01010 is completion with data (6) or without data (5). 01100 is fetch-and-add (7). 11011 is deferrable memory write (8). Any type with format 100 is a prefix (9). Any other type gives out_err=2, reported one cycle after the first doubleword.
- R5: A configuration or completion type with a 4 DW format, or a fetch-and-add or deferrable write type with a no-data format, gives out_err=3, reported one cycle after the first doubleword.
- R6: out_done pulses for one cycle in the cycle after the last header beat is accepted, and every output changes only then. Fields that the reported kind does not carry read 0.
- R7: out_tc is bits 22:20 of the first doubleword. out_pay_dw is the 10-bit length field in bits 9:0, with 0 meaning 1024, when data is present, and 0 otherwise. For a prefix both read 0.
- R8: For memory, configuration, fetch-and-add and deferrable-write requests, doubleword 1 gives requester ID [31:16], tag [15:8], last byte enable [7:4] and first byte enable [3:0]. Memory, fetch-and-add and deferrable-write requests give a 64-bit address: doubleword 2 zero-extended for a 3 DW header, or doubleword 2 as the upper half and doubleword 3 as the lower half for a 4 DW header.
- R9: Configuration requests take from doubleword 2 the bus [31:24], device [23:19], function [18:16] and register number [11:2].
- R10: Completions take from doubleword 1 the completer ID [31:16], status [15:13] and byte count [11:0]. From doubleword 2 they take requester ID [31:16], tag [15:8] and all seven bits of the lower address [6:0]. Their address and byte enables read 0.
- R11: out_non_posted is 1 for memory read, configuration, fetch-and-add and deferrable write, and 0 for memory write, completions and prefixes.
- R12: An error code stays on out_err until the next accepted start beat, which clears it to 0 in the following cycle unless that beat completes with an error itself.
- R13: A start beat that arrives before the current header is complete discards that header; it raises no done for it, and decoding restarts from the new beat.
- R14: Beats whose valid is low are gaps inside a header, and beats that are valid but not a start while no header is in progress are ignored with no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_sop | input | 1 | First doubleword of a packet |
| in_dw | input | 32 | Header doubleword, byte 0 in bits 31:24 |
| out_done | output | 1 | One-cycle pulse: results updated |
| out_err | output | 2 | 0 none, 1 reserved format, 2 unknown type, 3 illegal pairing |
| out_kind | output | 4 | Packet kind code (see R4) |
| out_hdr_dw | output | 3 | Header length in doublewords |
| out_has_data | output | 1 | Payload follows the header |
| out_non_posted | output | 1 | Request expects a completion |
| out_tc | output | 3 | Traffic class |
| out_pay_dw | output | 11 | Payload length in doublewords |
| out_req_id | output | 16 | Requester ID |
| out_tag | output | 8 | Tag |
| out_last_be | output | 4 | Last doubleword byte enables |
| out_first_be | output | 4 | First doubleword byte enables |
| out_addr | output | 64 | Request address |
| out_bus | output | 8 | Configuration bus number |
| out_dev | output | 5 | Configuration device number |
| out_func | output | 3 | Configuration function number |
| out_reg | output | 10 | Configuration register number |
| out_cpl_id | output | 16 | Completer ID |
| out_cpl_status | output | 3 | Completion status |
| out_byte_cnt | output | 12 | Completion byte count |
| out_lower_addr | output | 7 | Completion lower address |

## Verification
The bench aims at the places where a decoder fails silently. It checks that a 4 DW header routes doubleword 2 to the upper address half and does not leave the address 32 bits wide. It checks that a zero length field reports 1024 doublewords rather than none, and that a lower address of 0x7F keeps its top bit. Illegal format and type pairings must be rejected after one beat and not decoded as a valid kind. A restarting start beat, stray non-start beats and idle gaps inside a header probe the beat sequencing: a design that counted them wrongly would pulse done for a discarded header, late or twice. Back-to-back one-beat prefixes test done on consecutive cycles, and the error-hold case tests that a stale code clears only on the next start beat.

// File: rtl/tlp_dec_pkg.sv
// Package tlp_dec_pkg
// Shared widths, code points and record types of the header decoder.
// Assumes big-endian byte order inside each 32-bit doubleword.
package tlp_dec_pkg;

    localparam int DW_W     = 32;
    localparam int ADDR_W   = 64;
    localparam int LEN_W    = 10;
    localparam int PAY_W    = LEN_W + 1;
    localparam int MAX_HDR  = 4;
    localparam int IDX_W    = $clog2(MAX_HDR);
    localparam int HSZ_W    = $clog2(MAX_HDR) + 1;

    localparam logic [4:0] TY_MEM  = 5'b00000;
    localparam logic [4:0] TY_CFG0 = 5'b00100;
    localparam logic [4:0] TY_CPL  = 5'b01010;
    localparam logic [4:0] TY_FADD = 5'b01100;
    localparam logic [4:0] TY_DMWR = 5'b11011;
    localparam logic [2:0] FM_PREFIX = 3'b100;

    typedef enum logic [3:0] {
        K_NONE   = 4'd0,
        K_MEM_RD = 4'd1,
        K_MEM_WR = 4'd2,
        K_CFG_RD = 4'd3,
        K_CFG_WR = 4'd4,
        K_CPL    = 4'd5,
        K_CPLD   = 4'd6,
        K_FADD   = 4'd7,
        K_DMWR   = 4'd8,
        K_PREFIX = 4'd9
    } tlp_kind_e;

    typedef enum logic [1:0] {
        E_NONE  = 2'd0,
        E_FMT   = 2'd1,
        E_TYPE  = 2'd2,
        E_COMBO = 2'd3
    } tlp_err_e;

    typedef struct packed {
        tlp_kind_e        kind;
        tlp_err_e         err;
        logic [HSZ_W-1:0] hdr_dw;
        logic             has_data;
        logic             non_posted;
    } tlp_class_t;

    typedef struct packed {
        logic [2:0]        tc;
        logic [PAY_W-1:0]  pay_dw;
        logic [15:0]       req_id;
        logic [7:0]        tag;
        logic [3:0]        last_be;
        logic [3:0]        first_be;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        bus;
        logic [4:0]        dev;
        logic [2:0]        func;
        logic [9:0]        regn;
        logic [15:0]       cpl_id;
        logic [2:0]        cpl_status;
        logic [11:0]       byte_cnt;
        logic [6:0]        lower_addr;
    } tlp_fields_t;

endpackage

// File: rtl/tlp_dw0_classify.sv
// Module tlp_dw0_classify
// Classifies a packet from the format and type bits of its first doubleword
// (byte 0 only). Purely combinational. On any error every other result is 0.
module tlp_dw0_classify
    import tlp_dec_pkg::*;
(
    input  logic [7:0] dw0_b0,
    output tlp_class_t cls
);

    logic [2:0] fmt;
    logic [4:0] typ;
    logic       four;
    logic       data;

    assign fmt  = dw0_b0[7:5];
    assign typ  = dw0_b0[4:0];
    assign four = fmt[0];
    assign data = fmt[1];

    // Map format and type to kind, size, data presence, ordering class or error.
    always_comb begin
        cls = '0;
        if (fmt == FM_PREFIX) begin
            cls.kind   = K_PREFIX;
            cls.hdr_dw = HSZ_W'(1);
        end else if (fmt[2]) begin
            cls.err = E_FMT;
        end else begin
            unique case (typ)
                TY_MEM: begin
                    cls.kind       = data ? K_MEM_WR : K_MEM_RD;
                    cls.non_posted = !data;
                end
                TY_CFG0: begin
                    if (four) cls.err = E_COMBO;
                    else begin
                        cls.kind       = data ? K_CFG_WR : K_CFG_RD;
                        cls.non_posted = 1'b1;
                    end
                end
                TY_CPL: begin
                    if (four) cls.err = E_COMBO;
                    else cls.kind = data ? K_CPLD : K_CPL;
                end
                TY_FADD, TY_DMWR: begin
                    if (!data) cls.err = E_COMBO;
                    else begin
                        cls.kind       = (typ == TY_FADD) ? K_FADD : K_DMWR;
                        cls.non_posted = 1'b1;
                    end
                end
                default: cls.err = E_TYPE;
            endcase
            if (cls.err == E_NONE) begin
                cls.hdr_dw   = four ? HSZ_W'(4) : HSZ_W'(3);
                cls.has_data = data;
            end
        end
    end

endmodule

// File: rtl/tlp_beat_seq.sv
// Module tlp_beat_seq
// Tracks the beats of one header: index of the current beat, the class
// latched from the first beat, and the strobe for the final beat.
// A start beat always restarts; non-start beats count only mid-header.
module tlp_beat_seq
    import tlp_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  tlp_class_t       cls_now,
    output logic             take,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output tlp_class_t       cls_use
);

    logic             busy;
    logic [IDX_W-1:0] idx_q;
    tlp_class_t       cls_q;

    // Accept decision, beat position and final-beat detection.
    always_comb begin
        take    = in_valid && (in_sop || busy);
        idx     = in_sop ? '0 : idx_q;
        cls_use = in_sop ? cls_now : cls_q;
        last    = take && ((cls_use.err != E_NONE) ||
                           ({1'b0, idx} == cls_use.hdr_dw - HSZ_W'(1)));
    end

    // Progress through the header and hold the first-beat class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx_q <= '0;
            cls_q <= '0;
        end else begin
            if (take) begin
                busy  <= !last;
                idx_q <= idx + 1'b1;
            end
            if (take && in_sop) cls_q <= cls_now;
        end
    end

endmodule

// File: rtl/tlp_field_extract.sv
// Module tlp_field_extract
// Picks the kind-specific fields out of header doublewords 1 to 3 and
// computes traffic class and payload size. Fields the kind lacks are 0.
module tlp_field_extract
    import tlp_dec_pkg::*;
(
    input  tlp_kind_e    kind,
    input  logic         has_data,
    input  logic         four_dw,
    input  logic [2:0]   tc_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic [MAX_HDR-1:1][DW_W-1:0] w,
    output tlp_fields_t  fld
);

    logic [ADDR_W-1:0] addr_sel;

    // Address routing by header length.
    assign addr_sel = four_dw ? {w[2], w[3]} : {{(ADDR_W-DW_W){1'b0}}, w[2]};

    // Field selection by packet kind.
    always_comb begin
        fld = '0;
        if (kind != K_NONE && kind != K_PREFIX) begin
            fld.tc = tc_in;
            if (has_data)
                fld.pay_dw = (len_in == '0) ? PAY_W'(1 << LEN_W) : PAY_W'(len_in);
        end
        unique case (kind)
            K_MEM_RD, K_MEM_WR, K_FADD, K_DMWR, K_CFG_RD, K_CFG_WR: begin
                fld.req_id   = w[1][31:16];
                fld.tag      = w[1][15:8];
                fld.last_be  = w[1][7:4];
                fld.first_be = w[1][3:0];
                if (kind == K_CFG_RD || kind == K_CFG_WR) begin
                    fld.bus  = w[2][31:24];
                    fld.dev  = w[2][23:19];
                    fld.func = w[2][18:16];
                    fld.regn = w[2][11:2];
                end else begin
                    fld.addr = addr_sel;
                end
            end
            K_CPL, K_CPLD: begin
                fld.cpl_id     = w[1][31:16];
                fld.cpl_status = w[1][15:13];
                fld.byte_cnt   = w[1][11:0];
                fld.req_id     = w[2][31:16];
                fld.tag        = w[2][15:8];
                fld.lower_addr = w[2][6:0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tlp_hdr_decoder.sv
// Module tlp_hdr_decoder
// Top of the non-flit header decoder. Captures header doublewords, runs
// classification and field extraction on the final beat, and registers
// all results with a one-cycle done pulse. Errors hold until the next start.
module tlp_hdr_decoder
    import tlp_dec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic [31:0] in_dw,
    output logic        out_done,
    output logic [1:0]  out_err,
    output logic [3:0]  out_kind,
    output logic [2:0]  out_hdr_dw,
    output logic        out_has_data,
    output logic        out_non_posted,
    output logic [2:0]  out_tc,
    output logic [10:0] out_pay_dw,
    output logic [15:0] out_req_id,
    output logic [7:0]  out_tag,
    output logic [3:0]  out_last_be,
    output logic [3:0]  out_first_be,
    output logic [63:0] out_addr,
    output logic [7:0]  out_bus,
    output logic [4:0]  out_dev,
    output logic [2:0]  out_func,
    output logic [9:0]  out_reg,
    output logic [15:0] out_cpl_id,
    output logic [2:0]  out_cpl_status,
    output logic [11:0] out_byte_cnt,
    output logic [6:0]  out_lower_addr
);

    tlp_class_t       cls_now;
    tlp_class_t       cls_use;
    logic             take;
    logic             last;
    logic [IDX_W-1:0] idx;

    logic [2:0]       tc_q, tc_m;
    logic [LEN_W-1:0] len_q, len_m;
    logic [MAX_HDR-1:1][DW_W-1:0] hdr_q;
    logic [MAX_HDR-1:1][DW_W-1:0] hdr_m;
    tlp_fields_t      fld_next, fld_q;
    tlp_class_t       res_q;
    tlp_err_e         err_q;
    logic             done_q;

    tlp_dw0_classify i_classify (
        .dw0_b0 (in_dw[31:24]),
        .cls    (cls_now)
    );

    tlp_beat_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .cls_now  (cls_now),
        .take     (take),
        .idx      (idx),
        .last     (last),
        .cls_use  (cls_use)
    );

    // First-doubleword fields: live on the start beat, stored afterwards.
    assign tc_m  = in_sop ? in_dw[22:20] : tc_q;
    assign len_m = in_sop ? in_dw[LEN_W-1:0] : len_q;

    // Per-slot merge of the word arriving this beat with stored words.
    for (genvar g = 1; g < MAX_HDR; g++) begin : g_merge
        assign hdr_m[g] = (take && idx == IDX_W'(g)) ? in_dw : hdr_q[g];
    end

    tlp_field_extract i_extract (
        .kind     (cls_use.kind),
        .has_data (cls_use.has_data),
        .four_dw  (cls_use.hdr_dw == HSZ_W'(4)),
        .tc_in    (tc_m),
        .len_in   (len_m),
        .w        (hdr_m),
        .fld      (fld_next)
    );

    // Store header words and first-word fields as beats are accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
            tc_q  <= '0;
            len_q <= '0;
        end else if (take) begin
            hdr_q <= hdr_m;
            if (in_sop) begin
                tc_q  <= in_dw[22:20];
                len_q <= in_dw[LEN_W-1:0];
            end
        end
    end

    // Register results on the final beat; clear the error on a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= '0;
            fld_q  <= '0;
            err_q  <= E_NONE;
        end else begin
            done_q <= last;
            if (last) begin
                res_q <= cls_use;
                fld_q <= fld_next;
                err_q <= cls_use.err;
            end else if (take && in_sop) begin
                err_q <= E_NONE;
            end
        end
    end

    assign out_done       = done_q;
    assign out_err        = err_q;
    assign out_kind       = res_q.kind;
    assign out_hdr_dw     = res_q.hdr_dw;
    assign out_has_data   = res_q.has_data;
    assign out_non_posted = res_q.non_posted;
    assign out_tc         = fld_q.tc;
    assign out_pay_dw     = fld_q.pay_dw;
    assign out_req_id     = fld_q.req_id;
    assign out_tag        = fld_q.tag;
    assign out_last_be    = fld_q.last_be;
    assign out_first_be   = fld_q.first_be;
    assign out_addr       = fld_q.addr;
    assign out_bus        = fld_q.bus;
    assign out_dev        = fld_q.dev;
    assign out_func       = fld_q.func;
    assign out_reg        = fld_q.regn;
    assign out_cpl_id     = fld_q.cpl_id;
    assign out_cpl_status = fld_q.cpl_status;
    assign out_byte_cnt   = fld_q.byte_cnt;
    assign out_lower_addr = fld_q.lower_addr;

endmodule

// File: rtl/tlp_dec_checker.sv
// Module tlp_dec_checker
// Temporal properties of the header decoder ports, bound to every instance.
module tlp_dec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_sop,
    input logic        out_done,
    input logic [1:0]  out_err,
    input logic [3:0]  out_kind,
    input logic [2:0]  out_hdr_dw,
    input logic        out_has_data,
    input logic        out_non_posted,
    input logic [10:0] out_pay_dw,
    input logic [15:0] out_req_id,
    input logic [63:0] out_addr
);

    AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(in_valid)); // R6

    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> ($stable(out_addr) && $stable(out_kind) && $stable(out_req_id))); // R6

    AST_NODATA_NO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !out_has_data) |-> out_pay_dw == 11'd0); // R7

    AST_DATA_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_has_data) |-> (out_pay_dw != 11'd0 && out_pay_dw <= 11'd1024)); // R7

    AST_ERR_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_err != 2'd0) |-> (out_kind == 4'd0 && out_hdr_dw == 3'd0)); // R3

    AST_ERR_CHANGE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_err) |-> (out_done || $past(in_valid && in_sop))); // R12

    AST_PREFIX_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_kind == 4'd9) |-> !out_non_posted); // R11

    AST_CPL_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && (out_kind == 4'd5 || out_kind == 4'd6)) |-> out_addr == 64'd0); // R10

endmodule

bind tlp_hdr_decoder tlp_dec_checker i_dec_checker (.*);

// File: tb/test_tlp_hdr_decoder.sv
// Bench for tlp_hdr_decoder: behavioural model with a word queue, compared
// against every output on each falling edge, plus directed value checks.
module test_tlp_hdr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [31:0] in_dw = '0;
    logic        out_done, out_has_data, out_non_posted;
    logic [1:0]  out_err;
    logic [3:0]  out_kind, out_last_be, out_first_be;
    logic [2:0]  out_hdr_dw, out_tc, out_func, out_cpl_status;
    logic [10:0] out_pay_dw;
    logic [15:0] out_req_id, out_cpl_id;
    logic [7:0]  out_tag, out_bus;
    logic [63:0] out_addr;
    logic [4:0]  out_dev;
    logic [9:0]  out_reg;
    logic [11:0] out_byte_cnt;
    logic [6:0]  out_lower_addr;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    tlp_hdr_decoder i_tlp_hdr_decoder (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] mq[$];
    bit          mbusy;
    logic [63:0] e_done, e_err, e_kind, e_hdr, e_has, e_np, e_tc, e_pay, e_req, e_tag,
                 e_lbe, e_fbe, e_addr, e_bus, e_dev, e_fn, e_reg, e_cid, e_st, e_bc, e_la;

    function automatic void m_clear();
        e_kind = 0; e_hdr = 0; e_has = 0; e_np = 0; e_tc = 0; e_pay = 0; e_req = 0; e_tag = 0;
        e_lbe = 0; e_fbe = 0; e_addr = 0; e_bus = 0; e_dev = 0; e_fn = 0; e_reg = 0;
        e_cid = 0; e_st = 0; e_bc = 0; e_la = 0;
    endfunction

    function automatic void m_step();
        int fmt = int'(mq[0][31:29]);
        int typ = int'(mq[0][28:24]);
        int need;
        int kind = 0;
        int err = 0;
        bit data = mq[0][30];
        bit four = mq[0][29];
        if (fmt == 4) begin need = 1; kind = 9; end
        else if (fmt > 4) begin need = 1; err = 1; end
        else begin
            need = four ? 4 : 3;
            if (typ == 0) kind = data ? 2 : 1;
            else if (typ == 4) begin if (four) err = 3; else kind = data ? 4 : 3; end
            else if (typ == 10) begin if (four) err = 3; else kind = data ? 6 : 5; end
            else if (typ == 12) begin if (!data) err = 3; else kind = 7; end
            else if (typ == 27) begin if (!data) err = 3; else kind = 8; end
            else err = 2;
        end
        if (err != 0) begin
            m_clear(); e_err = err; e_done = 1; mbusy = 0;
        end else if (mq.size() == need) begin
            m_clear();
            e_err = 0; e_done = 1; mbusy = 0;
            e_kind = kind; e_hdr = need;
            if (kind != 9) begin
                e_has = data;
                e_tc = mq[0][22:20];
                if (data) e_pay = (mq[0][9:0] == 0) ? 1024 : mq[0][9:0];
                e_np = (kind == 1 || kind == 3 || kind == 4 || kind == 7 || kind == 8);
            end
            if (kind >= 1 && kind <= 4 || kind == 7 || kind == 8) begin
                e_req = mq[1][31:16]; e_tag = mq[1][15:8];
                e_lbe = mq[1][7:4];   e_fbe = mq[1][3:0];
            end
            if (kind == 3 || kind == 4) begin
                e_bus = mq[2][31:24]; e_dev = mq[2][23:19];
                e_fn = mq[2][18:16];  e_reg = mq[2][11:2];
            end else if (kind == 1 || kind == 2 || kind == 7 || kind == 8) begin
                e_addr = (need == 4) ? {mq[2], mq[3]} : {32'h0, mq[2]};
            end
            if (kind == 5 || kind == 6) begin
                e_cid = mq[1][31:16]; e_st = mq[1][15:13]; e_bc = mq[1][11:0];
                e_req = mq[2][31:16]; e_tag = mq[2][15:8]; e_la = mq[2][6:0];
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); mbusy = 0; e_done = 0; e_err = 0; m_clear();
        end else begin
            e_done = 0;
            if (in_valid) begin
                if (in_sop) begin mq.delete(); mbusy = 1; e_err = 0; end
                if (mbusy) begin mq.push_back(in_dw); m_step(); end
            end
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 done", out_done, e_done);
            chk("R12 err", out_err, e_err);
            chk("R4 kind", out_kind, e_kind);
            chk("R2 hdr_dw", out_hdr_dw, e_hdr);
            chk("R2 has_data", out_has_data, e_has);
            chk("R11 non_posted", out_non_posted, e_np);
            chk("R7 tc", out_tc, e_tc);
            chk("R7 pay_dw", out_pay_dw, e_pay);
            chk("R8 req/tag/be", {out_req_id, out_tag, out_last_be, out_first_be},
                {e_req[15:0], e_tag[7:0], e_lbe[3:0], e_fbe[3:0]});
            chk("R8 addr", out_addr, e_addr);
            chk("R9 cfg", {out_bus, out_dev, out_func, out_reg},
                {e_bus[7:0], e_dev[4:0], e_fn[2:0], e_reg[9:0]});
            chk("R10 cpl", {out_cpl_id, out_cpl_status, out_byte_cnt, out_lower_addr},
                {e_cid[15:0], e_st[2:0], e_bc[11:0], e_la[6:0]});
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [31:0] a, b, c, d, input int n, input int gap);
        logic [31:0] w [4];
        w = '{a, b, c, d};
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_sop = (i == 0); in_dw = w[i];
            @(negedge clk);
            if (gap > 0 && i < n - 1) begin
                in_valid = 1'b0; in_sop = 1'b0; in_dw = 32'h5A5A_A5A5;
                repeat (gap) @(negedge clk);
            end
        end
        in_valid = 1'b0; in_sop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 done", out_done, 0);
        chk("R1 err", out_err, 0);
        chk("R1 kind", out_kind, 0);
        chk("R1 addr", out_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 memory read, 3 DW
        send(32'h0000_0001, 32'h0000_200F, 32'hF620_000C, 0, 3, 0);
        chk("R8 addr32", out_addr, 64'hF620_000C);
        chk("R8 tag", out_tag, 8'h20);
        chk("R11 read non-posted", out_non_posted, 1);
        // R14 gaps inside a header
        send(32'h4000_0001, 32'h0000_200F, 32'hDEAD_0000, 0, 3, 2);
        chk("R4 mem write", out_kind, 2);
        chk("R11 write posted", out_non_posted, 0);
        // R8 4 DW write with TC 4
        send(32'h6040_0001, 32'hBEEF_A500, 32'h0000_0001, 32'h0000_0000, 4, 0);
        chk("R8 addr64", out_addr, 64'h0000_0001_0000_0000);
        chk("R7 tc", out_tc, 3'd4);
        chk("R8 req_id", out_req_id, 16'hBEEF);
        send(32'h2000_0000, 32'h1234_56F1, 32'h89AB_CDEF, 32'h0123_4567, 4, 1);
        chk("R7 no data len", out_pay_dw, 0);
        // R9 configuration
        send(32'h4400_0001, 32'h0001_000F, 32'hC208_0010, 0, 3, 0);
        chk("R9 bus", out_bus, 8'hC2);
        chk("R9 dev", out_dev, 5'd1);
        chk("R9 reg", out_reg, 10'd4);
        send(32'h0400_0000, 32'h0002_0103, 32'hFFFF_0FFC, 0, 3, 0);
        chk("R9 dev max", out_dev, 5'h1F);
        chk("R9 reg max", out_reg, 10'h3FF);
        // R10 completions
        send(32'h4A00_2040, 32'h2001_0040, 32'h1234_AB10, 0, 3, 0);
        chk("R10 cpl_id", out_cpl_id, 16'h2001);
        chk("R10 lower addr", out_lower_addr, 7'h10);
        chk("R7 len 64", out_pay_dw, 11'd64);
        send(32'h0A00_0000, 32'h2001_A004, 32'h5678_CD7F, 0, 3, 0);
        chk("R10 lower addr bit6", out_lower_addr, 7'h7F);
        chk("R10 status", out_cpl_status, 3'd5);
        // fetch-add and deferrable write
        send(32'h4C00_0000, 32'hABCD_0100, 32'h0000_1000, 0, 3, 0);
        chk("R7 len zero is 1024", out_pay_dw, 11'd1024);
        chk("R4 fetch-add", out_kind, 7);
        send(32'h7B00_0002, 32'h0000_0000, 32'h0000_0002, 32'h0000_0040, 4, 0);
        chk("R11 deferrable non-posted", out_non_posted, 1);
        // R2 back-to-back prefixes
        send(32'h8D00_0000, 0, 0, 0, 1, 0);
        send(32'h8000_0000, 0, 0, 0, 1, 0);
        chk("R2 prefix size", out_hdr_dw, 1);
        // R3 reserved format, R12 hold and clear
        send(32'hA000_0000, 0, 0, 0, 1, 0);
        chk("R3 reserved fmt", out_err, 1);
        repeat (3) @(negedge clk);
        chk("R12 err held", out_err, 1);
        in_valid = 1'b1; in_sop = 1'b1; in_dw = 32'h0000_0001;
        @(negedge clk);
        chk("R12 err cleared", out_err, 0);
        in_sop = 1'b0; in_dw = 32'h0000_000F;
        @(negedge clk);
        in_dw = 32'h0000_0100;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 next decode", out_addr, 64'h100);
        // R4 unknown type; trailing non-start beats ignored (R14)
        send(32'h0200_0000, 32'h1111_1111, 32'h2222_2222, 0, 3, 0);
        chk("R4 unknown type", out_err, 2);
        chk("R14 trailing ignored", out_done, 0);
        // R5 illegal pairings
        send(32'h2400_0000, 0, 0, 0, 1, 0);
        chk("R5 cfg 4DW", out_err, 3);
        send(32'h2A00_0000, 0, 0, 0, 1, 0);
        chk("R5 cpl 4DW", out_err, 3);
        send(32'h0C00_0000, 0, 0, 0, 1, 0);
        chk("R5 fetch-add no data", out_err, 3);
        send(32'h1B00_0000, 0, 0, 0, 1, 0);
        chk("R5 deferrable no data", out_err, 3);
        // R13 restart mid-header
        send(32'h4000_0001, 32'h0000_AA0F, 0, 0, 2, 0);
        send(32'h0000_0001, 32'h0000_770F, 32'h0000_0800, 0, 3, 0);
        chk("R13 restart kind", out_kind, 1);
        chk("R13 restart tag", out_tag, 8'h77);
        // R14 stray non-start beats while idle
        in_valid = 1'b1; in_sop = 1'b0; in_dw = 32'h4400_0001;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        chk("R14 stray no done", out_done, 0);
        chk("R14 stray kind held", out_kind, 1);
        repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule